// File: doc/BRIEF.md
# CCK Chip-Phase Encoder

This block turns data symbols into 8-chip complementary-code words for a high-rate direct-sequence baseband transmitter. Each chip leaves the block as a 2-bit phase index in quarter turns (0 = 0°, 1 = 90°, 2 = 180°, 3 = 270°). A downstream I/Q lookup or constellation mapper turns that index into a complex sample. There are two rates. The low rate carries a 4-bit nibble per symbol. The high rate carries a full byte per symbol.

Each chip phase is a mod-4 sum drawn from four per-symbol phase terms. The first term is coded differentially: the block keeps the running value of the first phase from one symbol to the next, and it also tracks whether the symbol index is even or odd. A symbol is accepted through a valid/ready handshake. The block then emits eight consecutive chips with a chip-valid strobe and raises ready again. Bit dN of a symbol is `in_data[N]`.

Top module: `cck_encoder`

## Requirements
- R1: After reset, `chip_valid` is 0 and `in_ready` is 1. The differential phase state and the symbol parity both restart at 0, so the next symbol accepted is symbol index 0, which is even.
- R2: A symbol is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Starting on the next cycle, `chip_valid` is high for exactly 8 consecutive cycles and `chip_first` is high on the first of them only. `in_ready` is 0 during those 8 cycles and returns to 1 on the cycle after the last chip.
- R3: With phases p1..p4 and all sums taken mod 4, the chips come out in this order: p1+p2+p3+p4, p1+p3+p4, p1+p2+p4, p1+p4+2, p1+p2+p3, p1+p3, p1+p2+2, p1.
- R4: The fourth chip and the seventh chip each carry an extra half-turn (+2).
- R5: The differential step for p1 comes from the pair {d0,d1}, with d0 read as the high bit: 00→0, 01→1, 11→2, 10→3. The step is added to the p1 of the previous accepted symbol.
- R6: Odd-indexed symbols get a further +2 on p1. The index counts the symbols accepted since reset, and the rotated value becomes the state used by the next symbol.
- R7: At the high rate (`rate_hi`=1), p2={d2,d3}, p3={d4,d5} and p4={d6,d7}, with the first-named bit as the MSB of each pair.
- R8: At the low rate (`rate_hi`=0), p2=2·d2+1, p3=0 and p4=2·d3. Bits d4..d7 have no effect.
- R9: `rate_hi` and `in_data` are sampled only at acceptance. Changing them while chips are being emitted does not alter those chips.
- R10: When `in_valid` is high while `in_ready` is low, nothing is accepted. The p1 state and the parity are left unchanged.
- R11: The p1 state and the parity are shared by both rates and carry across rate changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_hi | input | 1 | 1 = 8 bits per symbol, 0 = 4 bits per symbol |
| in_valid | input | 1 | Symbol data valid |
| in_data | input | 8 | Symbol bits, d0 in bit 0 |
| in_ready | output | 1 | Block can accept a symbol this cycle |
| chip_valid | output | 1 | Chip phase output valid |
| chip_first | output | 1 | Marks chip c0 of a symbol |
| chip_phase | output | 2 | Chip phase in quarter turns |

## Verification
The hardest condition to reach from the ports is the differential state after a long and irregular history: odd and even parity mixed with rate switches, rejected offers made while busy, and input changes in the middle of a symbol. Any slip in the accumulator would show up only in later symbols. The stimulus sends several hundred seeded random symbols with random rates and idle gaps. While chips are being emitted it toggles `in_valid`, `in_data` and `rate_hi`. A reset in the middle of the run checks that the state restarts at zero.

// File: rtl/cck_pkg.sv
package cck_pkg;

    localparam int CHIPS_PER_SYM = 8;
    localparam int CHIP_IDX_W    = $clog2(CHIPS_PER_SYM);
    localparam int IN_W          = 8;
    localparam int PH_W          = 2;

    typedef logic [PH_W-1:0] qphase_t;

    typedef enum logic {
        RATE_LOW  = 1'b0,
        RATE_HIGH = 1'b1
    } rate_e;

    typedef struct packed {
        qphase_t p1;
        qphase_t p2;
        qphase_t p3;
        qphase_t p4;
    } sym_phase_t;

    localparam qphase_t HALF_TURN = qphase_t'(2);

    // Gray-ordered differential step for the first phase term
    function automatic qphase_t dqpsk_step(input logic hi, input logic lo);
        qphase_t r;
        case ({hi, lo})
            2'b00:   r = qphase_t'(0);
            2'b01:   r = qphase_t'(1);
            2'b11:   r = qphase_t'(2);
            default: r = qphase_t'(3);
        endcase
        return r;
    endfunction

    // Natural binary mapping for the remaining phase terms
    function automatic qphase_t qpsk_pt(input logic hi, input logic lo);
        return {hi, lo};
    endfunction

    // Phase of chip k of a symbol, all arithmetic mod 4
    function automatic qphase_t chip_of(input sym_phase_t s, input int unsigned k);
        qphase_t r;
        case (k)
            0:       r = s.p1 + s.p2 + s.p3 + s.p4;
            1:       r = s.p1 + s.p3 + s.p4;
            2:       r = s.p1 + s.p2 + s.p4;
            3:       r = s.p1 + s.p4 + HALF_TURN;
            4:       r = s.p1 + s.p2 + s.p3;
            5:       r = s.p1 + s.p3;
            6:       r = s.p1 + s.p2 + HALF_TURN;
            default: r = s.p1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cck_symbol_map.sv
module cck_symbol_map
    import cck_pkg::*;
(
    input  logic [IN_W-1:0] data,
    input  rate_e           rate,
    output qphase_t         delta,
    output qphase_t         p2,
    output qphase_t         p3,
    output qphase_t         p4
);

    always_comb begin
        delta = dqpsk_step(data[0], data[1]);
        if (rate == RATE_HIGH) begin
            p2 = qpsk_pt(data[2], data[3]);
            p3 = qpsk_pt(data[4], data[5]);
            p4 = qpsk_pt(data[6], data[7]);
        end else begin
            p2 = {data[2], 1'b1};
            p3 = qphase_t'(0);
            p4 = {data[3], 1'b0};
        end
    end

endmodule

// File: rtl/cck_diff_phase.sv
module cck_diff_phase
    import cck_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    accept,
    input  qphase_t delta,
    output qphase_t p1_next
);

    qphase_t acc_q;
    logic    odd_q;

    always_comb begin
        p1_next = acc_q + delta + (odd_q ? HALF_TURN : qphase_t'(0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            odd_q <= 1'b0;
        end else if (accept) begin
            acc_q <= p1_next;
            odd_q <= ~odd_q;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) rst |=> (acc_q == '0) && !odd_q);
    // R6
    parity_flip_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> odd_q != $past(odd_q));
    // R10
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(acc_q) && $stable(odd_q));

endmodule

// File: rtl/cck_chip_sched.sv
module cck_chip_sched
    import cck_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  sym_phase_t sym_in,
    output logic       busy,
    output logic       chip_valid,
    output logic       chip_first,
    output qphase_t    chip_phase
);

    localparam logic [CHIP_IDX_W-1:0] LAST = CHIP_IDX_W'(CHIPS_PER_SYM - 1);

    sym_phase_t              sym_q;
    logic [CHIP_IDX_W-1:0]   cnt_q;
    logic                    busy_q;
    qphase_t                 chip_tab [CHIPS_PER_SYM];

    for (genvar k = 0; k < CHIPS_PER_SYM; k++) begin : g_chip
        assign chip_tab[k] = chip_of(sym_q, k);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (accept) begin
            sym_q  <= sym_in;
            cnt_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
            end
        end
    end

    always_comb begin
        busy       = busy_q;
        chip_valid = busy_q;
        chip_first = busy_q && (cnt_q == '0);
        chip_phase = busy_q ? chip_tab[cnt_q] : qphase_t'(0);
    end

    // R2
    burst_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> $past(cnt_q) == LAST);
    // R9
    sym_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q && !accept |=> $stable(sym_q));
    // R3
    last_chip_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q && (cnt_q == LAST) |-> chip_phase == sym_q.p1);

endmodule

// File: rtl/cck_encoder.sv
module cck_encoder
    import cck_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            rate_hi,
    input  logic            in_valid,
    input  logic [IN_W-1:0] in_data,
    output logic            in_ready,
    output logic            chip_valid,
    output logic            chip_first,
    output logic [PH_W-1:0] chip_phase
);

    rate_e      rate;
    logic       busy;
    logic       accept;
    qphase_t    delta;
    qphase_t    p1_next;
    sym_phase_t sym_new;

    assign rate     = rate_e'(rate_hi);
    assign in_ready = !busy;
    assign accept   = in_valid && in_ready;

    cck_symbol_map u_map (
        .data  (in_data),
        .rate  (rate),
        .delta (delta),
        .p2    (sym_new.p2),
        .p3    (sym_new.p3),
        .p4    (sym_new.p4)
    );

    cck_diff_phase u_diff (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .delta   (delta),
        .p1_next (p1_next)
    );

    assign sym_new.p1 = p1_next;

    cck_chip_sched u_sched (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .sym_in     (sym_new),
        .busy       (busy),
        .chip_valid (chip_valid),
        .chip_first (chip_first),
        .chip_phase (chip_phase)
    );

    // R2
    start_chip_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> chip_valid && chip_first && !in_ready);
    // R10
    busy_reject_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && !in_ready && !chip_first |=> !chip_first);

endmodule

// File: tb/sim_cck_encoder.sv
module sim_cck_encoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rate_hi = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       chip_valid;
    logic       chip_first;
    logic [1:0] chip_phase;

    int checks = 0;
    int errors = 0;

    logic [1:0] m_acc = 2'd0;
    logic       m_odd = 1'b0;
    logic [1:0] e1, e2, e3, e4;

    always #4 clk = ~clk;

    cck_encoder u0 (
        .clk(clk), .rst(rst), .rate_hi(rate_hi), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .chip_valid(chip_valid),
        .chip_first(chip_first), .chip_phase(chip_phase)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] f_step(input logic d0, input logic d1);
        // R5 Gray step table
        if (!d0 && !d1) return 2'd0;
        if (!d0 &&  d1) return 2'd1;
        if ( d0 &&  d1) return 2'd2;
        return 2'd3;
    endfunction

    task automatic model_symbol(input logic [7:0] d, input logic hi);
        // R6 odd rotation, R11 shared state
        e1 = m_acc + f_step(d[0], d[1]) + (m_odd ? 2'd2 : 2'd0);
        m_acc = e1;
        m_odd = ~m_odd;
        if (hi) begin // R7
            e2 = {d[2], d[3]};
            e3 = {d[4], d[5]};
            e4 = {d[6], d[7]};
        end else begin // R8
            e2 = 2'(2 * d[2] + 1);
            e3 = 2'd0;
            e4 = 2'(2 * d[3]);
        end
    endtask

    function automatic logic [1:0] f_chip(input int k);
        logic [1:0] s;
        s = e1;
        if (k == 0 || k == 2 || k == 4 || k == 6) s = s + e2;
        if (k == 0 || k == 1 || k == 4 || k == 5) s = s + e3;
        if (k <= 3) s = s + e4;
        if (k == 3 || k == 6) s = s + 2'd2; // R4
        return s;
    endfunction

    task automatic send_sym(input logic [7:0] d, input logic hi, input bit noisy, input string tag);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        rate_hi  = hi;
        model_symbol(d, hi);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (noisy) begin // R9 and R10 disturbance while busy
                in_valid = 1'($urandom % 2);
                in_data  = 8'($urandom);
                rate_hi  = 1'($urandom % 2);
            end else begin
                in_valid = 1'b0;
            end
            if (k == 7) in_valid = 1'b0;
            chk(chip_valid === 1'b1, "R2 chip_valid", int'(chip_valid), 1);
            chk(chip_first === (k == 0), "R2 chip_first", int'(chip_first), int'(k == 0));
            chk(in_ready === 1'b0, "R2 ready low while busy", int'(in_ready), 0);
            chk(chip_phase === f_chip(k), tag, int'(chip_phase), int'(f_chip(k)));
        end
        @(negedge clk);
        chk(chip_valid === 1'b0 && in_ready === 1'b1, "R2 idle after 8 chips",
            int'({chip_valid, in_ready}), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(chip_valid === 1'b0, "R1 chip_valid after reset", int'(chip_valid), 0);
        chk(in_ready === 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

        // Directed: zero byte at high rate, then ones, then low-rate nibbles
        send_sym(8'h00, 1'b1, 1'b0, "R3 R4 zero symbol");
        send_sym(8'hFF, 1'b1, 1'b0, "R6 R7 odd symbol");
        send_sym(8'h05, 1'b0, 1'b0, "R8 low rate");
        send_sym(8'hF5, 1'b0, 1'b0, "R8 high nibble ignored");
        send_sym(8'h0E, 1'b0, 1'b1, "R9 R10 noisy low");
        send_sym(8'hB4, 1'b1, 1'b1, "R9 R10 noisy high");

        // R1: reset mid-run restarts state
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_acc = 2'd0;
        m_odd = 1'b0;
        chk(chip_valid === 1'b0 && in_ready === 1'b1, "R1 idle after second reset",
            int'({chip_valid, in_ready}), 1);
        send_sym(8'h02, 1'b1, 1'b0, "R1 state restarted");

        // Random mix: rates, gaps, disturbance
        for (int n = 0; n < 400; n++) begin
            int gap;
            gap = int'($urandom % 3);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                chk(chip_valid === 1'b0, "R2 idle gap", int'(chip_valid), 0);
            end
            send_sym(8'($urandom), 1'($urandom % 2), 1'($urandom % 2), "R3 R11 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule